// File: doc/BRIEF.md
# Slave-Serial Configuration Master

This block loads a bitstream into a target programmable device over a serial link that carries one bit per clock. Bytes arrive on a valid/ready stream, and the last byte of the image is marked. The block drives the program request, the serial clock and the serial data line toward the target. It watches the target's init-active and done indications. A start pulse begins a run. First comes the program handshake in two phases: the block waits for init to become active, then for it to clear. Each byte is then shifted out, most significant bit first. Before every byte the block looks for a checksum error. After the last byte it keeps pulsing the clock with the data line high until done is reported.

Every run ends in a result code. The code stays on the status output until the next start pulse. All pacing uses system clocks. Each serial phase lasts `PHASE_DLY` cycles. Each of the three waiting windows is limited to one hundredth of a second, computed from `CLK_HZ`.

States:
- `S_IDLE`: goes to `S_PROG_ON` on start.
- `S_PROG_ON`: goes to `S_SETTLE` once init is active, or back to idle on timeout.
- `S_SETTLE`: goes to `S_WAIT_CLR` after one phase.
- `S_WAIT_CLR`: goes to `S_FETCH` once init clears, or back to idle on timeout.
- `S_FETCH`: returns to idle on a checksum error, or goes to `S_CLK_LO` when a byte is taken.
- Bit states: `S_CLK_LO` goes to `S_DATA`, which goes to `S_CLK_HI`. After `S_CLK_HI` the next step is `S_CLK_LO` for the next bit, `S_FETCH` after a non-final byte, or `S_FLUSH` after the final byte.
- `S_FLUSH`: returns to idle on done or on timeout; otherwise it goes to `S_POST_LO`.
- `S_POST_LO` goes to `S_POST_HI`, which goes back to `S_FLUSH`.

Top module: `cfg_serial_master`

## Requirements
- R1: After reset and between runs the outputs are: program request 0, serial clock 1, serial data 1, stream ready 0, busy 0. The status is 0 after reset.
- R2: A start pulse in idle raises busy and the program request. If init is not active within `CLK_HZ/100` cycles, the run ends with status 2 and the program request drops.
- R3: Once init is seen active, the program request stays high for `PHASE_DLY` more cycles and is then released. If init has not cleared within `CLK_HZ/100` cycles of that release, the run ends with status 3.
- R4: Stream ready is high only while the block waits for a byte in the data phase, after the program request is released. One handshake transfers exactly one byte.
- R5: Each byte appears on the serial data line as exactly 8 bits, most significant bit first. One bit is valid at each rising edge of the serial clock.
- R6: For each bit the clock is low for `2*PHASE_DLY` cycles. The data line takes the new bit while the clock is low, and the data line stays unchanged while the clock is high. Between bytes the clock rests high.
- R7: In the byte-wait state, if init is active while done is low, the run ends with status 4. No byte is accepted in that cycle, even if one is offered.
- R8: After the final byte, the block drives the data line to 1 during every low phase. It keeps pulsing the clock until done is sampled high, then ends with status 1. It adds no rising edges after the one that preceded done.
- R9: If done is not seen within `CLK_HZ/100` cycles after the final byte, the run ends with status 5.
- R10: The status holds its result while idle. It is cleared to 0 in the cycle after an accepted start, and busy stays high until the result is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a load; honoured only when idle |
| s_data | input | BYTE_W | Bitstream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_valid | input | 1 | Byte offered |
| s_ready | output | 1 | Byte accepted this cycle when valid is high |
| cfg_prog | output | 1 | Program request to the target, active high |
| cfg_cclk | output | 1 | Serial configuration clock |
| cfg_din | output | 1 | Serial configuration data |
| init_act | input | 1 | Target init indication, 1 = active |
| done_in | input | 1 | Target done indication |
| busy | output | 1 | A run is in progress |
| status | output | 3 | Result: 0 none, 1 ok, 2 init-start timeout, 3 init-clear timeout, 4 checksum error, 5 done timeout |

## Verification
Two events can fall in the same byte-wait cycle: the checksum-error condition and a stream handshake. The bench sets this up by holding the next byte valid and raising init, with done low, just as the first byte's last bit is being clocked. The result is judged correct if the run ends with status 4, exactly one byte was consumed, and ready never rose while the error condition was present.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

    typedef enum logic [2:0] {
        CFG_NONE           = 3'd0,
        CFG_OK             = 3'd1,
        CFG_ERR_INIT_START = 3'd2,
        CFG_ERR_INIT_CLEAR = 3'd3,
        CFG_ERR_CRC        = 3'd4,
        CFG_ERR_DONE       = 3'd5
    } cfg_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PROG_ON,
        S_SETTLE,
        S_WAIT_CLR,
        S_FETCH,
        S_CLK_LO,
        S_DATA,
        S_CLK_HI,
        S_FLUSH,
        S_POST_LO,
        S_POST_HI
    } cfg_state_e;

endpackage

// File: rtl/cfg_phase_pacer.sv
// Phase pacer: pulses tick on the last cycle of each PHASE_DLY-long phase.
module cfg_phase_pacer #(
    parameter int PHASE_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = $clog2(PHASE_DLY + 1);

    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q == PW'(PHASE_DLY - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr || tick) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cfg_window_timer.sv
// Window timer: counts cycles since clr and saturates at LIMIT.
module cfg_window_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q == TW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cfg_byte_shifter.sv
// Byte shifter: loads a byte and presents it one bit at a time, MSB first.
module cfg_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic              msb,
    output logic              last_bit
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr_q;
    logic [CW-1:0]     bcnt_q;

    assign msb      = sr_q[BYTE_W-1];
    assign last_bit = (bcnt_q == CW'(BYTE_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q   <= '0;
            bcnt_q <= '0;
        end else if (load) begin
            sr_q   <= din;
            bcnt_q <= '0;
        end else if (shift) begin
            sr_q   <= {sr_q[BYTE_W-2:0], 1'b0};
            bcnt_q <= bcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
    import cfg_serial_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PHASE_DLY = 4,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_valid,
    output logic              s_ready,
    output logic              cfg_prog,
    output logic              cfg_cclk,
    output logic              cfg_din,
    input  logic              init_act,
    input  logic              done_in,
    output logic              busy,
    output logic [2:0]        status
);
    localparam int TMO_CYC = CLK_HZ / 100;

    cfg_state_e  state_q, state_d;
    cfg_status_e status_q, fin_code;
    logic        fin, tmr_clr, tmr_exp, tick, ld, sh;
    logic        msb, last_bit, last_q, din_q, crc_hit;

    assign crc_hit = init_act && !done_in;

    cfg_phase_pacer #(.PHASE_DLY(PHASE_DLY)) u_pacer (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .tick(tick)
    );

    cfg_window_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .expired(tmr_exp)
    );

    cfg_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(ld), .shift(sh), .din(s_data),
        .msb(msb), .last_bit(last_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control strobes
    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_code = CFG_NONE;
        tmr_clr  = 1'b0;
        ld       = 1'b0;
        sh       = 1'b0;
        unique case (state_q)
            S_IDLE: if (start) begin
                state_d = S_PROG_ON;
                tmr_clr = 1'b1;
            end
            S_PROG_ON: begin
                if (init_act) state_d = S_SETTLE;
                else if (tmr_exp) begin
                    fin = 1'b1; fin_code = CFG_ERR_INIT_START; state_d = S_IDLE;
                end
            end
            S_SETTLE: if (tick) begin
                state_d = S_WAIT_CLR;
                tmr_clr = 1'b1;
            end
            S_WAIT_CLR: begin
                if (!init_act) state_d = S_FETCH;
                else if (tmr_exp) begin
                    fin = 1'b1; fin_code = CFG_ERR_INIT_CLEAR; state_d = S_IDLE;
                end
            end
            S_FETCH: begin
                if (crc_hit) begin
                    fin = 1'b1; fin_code = CFG_ERR_CRC; state_d = S_IDLE;
                end else if (s_valid) begin
                    ld = 1'b1; state_d = S_CLK_LO;
                end
            end
            S_CLK_LO: if (tick) state_d = S_DATA;
            S_DATA:   if (tick) state_d = S_CLK_HI;
            S_CLK_HI: if (tick) begin
                sh = 1'b1;
                if (!last_bit)   state_d = S_CLK_LO;
                else if (last_q) begin
                    state_d = S_FLUSH; tmr_clr = 1'b1;
                end else         state_d = S_FETCH;
            end
            S_FLUSH: begin
                if (done_in) begin
                    fin = 1'b1; fin_code = CFG_OK; state_d = S_IDLE;
                end else if (tmr_exp) begin
                    fin = 1'b1; fin_code = CFG_ERR_DONE; state_d = S_IDLE;
                end else state_d = S_POST_LO;
            end
            S_POST_LO: if (tick) state_d = S_POST_HI;
            S_POST_HI: if (tick) state_d = S_FLUSH;
            default:   state_d = S_IDLE;
        endcase
    end

    // Registered data line, final-byte flag and result code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q    <= 1'b1;
            last_q   <= 1'b0;
            status_q <= CFG_NONE;
        end else begin
            if (state_q == S_DATA)                           din_q <= msb;
            else if (state_q == S_POST_LO || state_q == S_IDLE) din_q <= 1'b1;
            if (ld) last_q <= s_last;
            if (state_q == S_IDLE && start) status_q <= CFG_NONE;
            else if (fin)                   status_q <= fin_code;
        end
    end

    // Pin outputs
    always_comb begin
        s_ready  = (state_q == S_FETCH) && !crc_hit;
        cfg_prog = (state_q == S_PROG_ON) || (state_q == S_SETTLE);
        cfg_cclk = !((state_q == S_CLK_LO) || (state_q == S_DATA) || (state_q == S_POST_LO));
        cfg_din  = din_q;
        busy     = (state_q != S_IDLE);
        status   = status_q;
    end
endmodule

// File: rtl/cfg_serial_master_chk.sv
module cfg_serial_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       s_ready,
    input logic       cfg_prog,
    input logic       cfg_cclk,
    input logic       cfg_din,
    input logic       init_act,
    input logic       done_in,
    input logic       busy,
    input logic [2:0] status
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cfg_cclk && !cfg_prog && !s_ready));

    // R4
    ready_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (busy && !cfg_prog));

    // R7
    no_take_on_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !(init_act && !done_in));

    // R6
    din_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cfg_cclk && $past(cfg_cclk)) |-> $stable(cfg_din));

    // R10
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(status));

    // R10
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && status == 3'd0));

    // R2
    prog_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cfg_prog);
endmodule

bind cfg_serial_master cfg_serial_master_chk u_chk (.*);

// File: tb/sim_cfg_serial_master.sv
module sim_cfg_serial_master;
    localparam int CLK_PERIOD = 10;
    localparam int PD         = 2;
    localparam int HZ         = 100_000;
    localparam int TMO        = HZ / 100;

    logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0, s_valid = 1'b0;
    logic       init_act = 1'b0, done_in = 1'b0;
    logic       s_ready, cfg_prog, cfg_cclk, cfg_din, busy;
    logic [2:0] status;

    cfg_serial_master #(.CLK_HZ(HZ), .PHASE_DLY(PD), .BYTE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_last(s_last),
        .s_valid(s_valid), .s_ready(s_ready), .cfg_prog(cfg_prog), .cfg_cclk(cfg_cclk),
        .cfg_din(cfg_din), .init_act(init_act), .done_in(done_in), .busy(busy),
        .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    logic [7:0] tx[4];
    int popped, flush_rises, done_after, low_run, nbits, accepted, settle_cnt, cyc;
    bit no_init, stuck_init, crc_mode, ready_seen;
    logic [7:0] cur;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_vars();
        popped = 0; flush_rises = 0; nbits = 0; accepted = 0; settle_cnt = 0;
        no_init = 0; stuck_init = 0; crc_mode = 0; ready_seen = 0;
        done_after = 1; exp_q.delete();
    endtask

    always @(posedge clk) cyc++;

    // Monitor: pops expected bytes as bits appear, checks flush pulses
    initial begin
        logic prev;
        logic [7:0] e;
        prev = 1'b1; low_run = 0;
        forever begin
            @(negedge clk);
            if (s_ready) ready_seen = 1;
            if (!cfg_cclk) low_run++;
            else begin
                if (!prev && busy) begin
                    if (exp_q.size() > 0) begin
                        chk(low_run == 2*PD, "R6", low_run, 2*PD);
                        cur = {cur[6:0], cfg_din};
                        nbits++;
                        if (nbits == 8) begin
                            e = exp_q.pop_front();
                            chk(cur == e, "R5", cur, e);
                            popped++; nbits = 0;
                        end
                    end else begin
                        chk(cfg_din == 1'b1, "R8", cfg_din, 1);
                        flush_rises++;
                        if (flush_rises >= done_after) done_in = 1'b1;
                    end
                end
                low_run = 0;
            end
            prev = cfg_cclk;
        end
    end

    // Driver: offers bytes, pushes each into the scoreboard at handshake
    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            s_valid = 1'b1; s_data = tx[i]; s_last = (i == n-1);
            while (!s_ready && busy) @(negedge clk);
            if (!busy) break;
            exp_q.push_back(tx[i]); accepted++;
            @(negedge clk);
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    // Target model for init and the checksum condition
    task automatic target();
        if (!no_init) begin
            repeat (4) @(negedge clk);
            init_act = 1'b1;
        end
        while (cfg_prog) begin @(negedge clk); settle_cnt++; end
        if (!busy) return;
        if (!stuck_init) begin
            repeat (4) @(negedge clk);
            init_act = 1'b0;
        end
        if (crc_mode) begin
            wait (popped >= 1);
            init_act = 1'b1;
        end
        while (busy) @(negedge clk);
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R10", busy, 1);
        chk(status == 3'd0, "R10", status, 0);
    endtask

    task automatic settle_down();
        s_valid = 1'b0; init_act = 1'b0; done_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int t0;
        clear_vars(); cyc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_prog == 0, "R1", cfg_prog, 0);
        chk(cfg_cclk == 1, "R1", cfg_cclk, 1);
        chk(cfg_din == 1, "R1", cfg_din, 1);
        chk(s_ready == 0 && busy == 0, "R1", {s_ready, busy}, 0);
        chk(status == 0, "R1", status, 0);

        // Normal load, three bytes, done after three flush pulses
        clear_vars(); done_after = 3;
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h81;
        kick();
        fork send(3); target(); join
        @(negedge clk);
        chk(status == 3'd1, "R8", status, 1);
        chk(popped == 3, "R5", popped, 3);
        chk(accepted == 3, "R4", accepted, 3);
        chk(flush_rises == 3, "R8", flush_rises, 3);
        chk(settle_cnt == PD + 1, "R3", settle_cnt, PD + 1);
        repeat (20) @(negedge clk);
        chk(status == 3'd1 && !busy, "R10", status, 1);
        chk(cfg_din == 1 && cfg_cclk == 1, "R1", {cfg_din, cfg_cclk}, 3);
        settle_down();

        // Second pattern: two bytes, done after the first flush pulse
        clear_vars(); done_after = 1;
        tx[0] = 8'h00; tx[1] = 8'hFF;
        kick();
        fork send(2); target(); join
        @(negedge clk);
        chk(status == 3'd1, "R8", status, 1);
        chk(popped == 2, "R5", popped, 2);
        chk(flush_rises == 1, "R8", flush_rises, 1);
        settle_down();

        // Init never goes active, byte offered the whole time
        clear_vars(); no_init = 1; tx[0] = 8'h77;
        kick(); t0 = cyc - 1;
        fork send(1); target(); join
        while (busy) @(negedge clk);
        chk(status == 3'd2, "R2", status, 2);
        chk((cyc - t0) >= TMO && (cyc - t0) <= TMO + 4, "R2", cyc - t0, TMO);
        chk(cfg_prog == 0, "R2", cfg_prog, 0);
        chk(!ready_seen, "R4", ready_seen, 0);
        settle_down();

        // Init never clears after release
        clear_vars(); stuck_init = 1; tx[0] = 8'h12;
        kick();
        fork send(1); target(); join
        while (busy) @(negedge clk);
        chk(status == 3'd3, "R3", status, 3);
        chk(!ready_seen, "R4", ready_seen, 0);
        settle_down();

        // Checksum condition coincides with the next byte being offered
        clear_vars(); crc_mode = 1;
        tx[0] = 8'h5A; tx[1] = 8'hC3; tx[2] = 8'h11;
        kick();
        fork send(3); target(); join
        @(negedge clk);
        chk(status == 3'd4, "R7", status, 4);
        chk(popped == 1, "R7", popped, 1);
        chk(accepted == 1, "R7", accepted, 1);
        settle_down();

        // Done never arrives
        clear_vars(); done_after = 1_000_000; tx[0] = 8'h96;
        kick();
        fork send(1); target(); join
        @(negedge clk);
        chk(status == 3'd5, "R9", status, 5);
        chk(popped == 1, "R5", popped, 1);
        chk(flush_rises > 100, "R9", flush_rises, 101);
        settle_down();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150_000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule